// File: doc/BRIEF.md
# Interrupt State Set/Clear Register Bank

This block keeps three bits of state for every interrupt line: enabled, pending and active. Software reaches the state through a 32-bit word-addressed read/write port. The address space is split into six windows. Each window has one bit per interrupt. In a "set" window, a written 1 turns the bit on. In a "clear" window, a written 1 turns it off. Both windows of a pair read back the same current state.

Every line also has a configuration input that selects level or edge sensing, and a live line input. An edge line becomes pending on a rising edge of its line, and stays pending until software clears it. A level line has its own software pending latch. Its pending output is the OR of that latch and the live line. Clearing pending on a level line empties only the latch, so pending then follows the line.

The enable, pending and active vectors are driven out in parallel for a downstream arbiter.

Top module: `irq_state_bank`

## Requirements
- R1: After reset the enable, pending and active vectors are all zero, and every read returns 0.
- R2: A write to the set-enable window (byte offset 0x000) sets the enable bit of each interrupt whose data bit is 1. Bits written as 0 keep their value.
- R3: A write to the clear-enable window (offset 0x080) clears each enable bit written as 1. Reads of offset 0x000 and of offset 0x080 both return the enable bits.
- R4: Within a window, data bit b at byte offset w maps to interrupt w*8+b, so the word at window offset 4 holds interrupts 32 to 63. Bits for interrupt numbers at or above NUM_IRQ read 0, and writes to them have no effect.
- R5: A write to the set-pending window (offset 0x100) makes each interrupt written as 1 pending. Reads of 0x100 and of the clear-pending window (0x180) both return the effective pending bits.
- R6: For an edge line (level_cfg_i bit 0), a rising edge of line_i makes the interrupt pending. A clear-pending write then drops it, even while the line stays high. A rising edge in the same cycle as a clear-pending write leaves the interrupt pending.
- R7: For a level line (level_cfg_i bit 1), pending is the OR of its software latch and the live line. Set-pending sets the latch. Clear-pending empties the latch, so pending then equals the line level.
- R8: Writes to the set-active window (0x200) set active bits and writes to the clear-active window (0x280) clear them, per written 1. Both windows read back the active bits.
- R9: A write changes state at the clock edge that samples the write strobe, and not before. With the default RD_REG=0, rd_valid_o equals rd_en_i and read data appears in the same cycle. With RD_REG=1, both appear one cycle later.
- R10: An access is ignored if its two low address bits are not zero, or if its window index (address bits 9:7) is 6 or 7. Such a write changes nothing, and such a read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | WIN_LOG2+3 | Byte address of the access |
| wdata_i | input | 32 | Write data, one bit per interrupt |
| rdata_o | output | 32 | Read data |
| rd_valid_o | output | 1 | Read data valid |
| line_i | input | NUM_IRQ | Live interrupt line levels |
| level_cfg_i | input | NUM_IRQ | 1 = level sensing, 0 = edge sensing |
| enable_o | output | NUM_IRQ | Enable state vector |
| pending_o | output | NUM_IRQ | Effective pending vector |
| active_o | output | NUM_IRQ | Active state vector |

## Verification
The bench targets the clear-pending path, where the two sensing modes differ.
- A design that forced pending to zero on a level line would lose an interrupt that is still asserted.
- A design that let clear win over a simultaneous rising edge would lose that edge.

The bench also writes words whose zero bits must not disturb state, and addresses the upper word of a window to catch wrong interrupt numbering. It checks state in the strobe cycle itself, which exposes a write that lands early. Misaligned and unmapped accesses must leave all three vectors untouched.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  localparam int BUS_W = 32;

  typedef enum logic [2:0] {
    WIN_SET_EN = 3'd0,
    WIN_CLR_EN = 3'd1,
    WIN_SET_PD = 3'd2,
    WIN_CLR_PD = 3'd3,
    WIN_SET_AC = 3'd4,
    WIN_CLR_AC = 3'd5,
    WIN_NONE   = 3'd7
  } win_e;

  // Window index field of the address -> window kind; 6 and 7 are unmapped.
  function automatic win_e win_decode(input logic [2:0] sel);
    case (sel)
      3'd0:    return WIN_SET_EN;
      3'd1:    return WIN_CLR_EN;
      3'd2:    return WIN_SET_PD;
      3'd3:    return WIN_CLR_PD;
      3'd4:    return WIN_SET_AC;
      3'd5:    return WIN_CLR_AC;
      default: return WIN_NONE;
    endcase
  endfunction

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_bank_pkg::*;
#(
  parameter int NUM_IRQ  = 64,
  parameter int WIN_LOG2 = 7
) (
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic [WIN_LOG2+2:0]   addr_i,
  input  logic [BUS_W-1:0]      wdata_i,
  output logic [NUM_IRQ-1:0]    set_en_o,
  output logic [NUM_IRQ-1:0]    clr_en_o,
  output logic [NUM_IRQ-1:0]    set_pd_o,
  output logic [NUM_IRQ-1:0]    clr_pd_o,
  output logic [NUM_IRQ-1:0]    set_ac_o,
  output logic [NUM_IRQ-1:0]    clr_ac_o,
  output win_e                  rd_win_o,
  output logic [WIN_LOG2-3:0]   rd_word_o
);

  localparam int VEC_W = ((NUM_IRQ + BUS_W - 1) / BUS_W) * BUS_W;

  // Place a 32-bit data word at interrupt (word*32); lanes past NUM_IRQ drop out.
  function automatic logic [NUM_IRQ-1:0] spread(input logic [WIN_LOG2-3:0] word,
                                                input logic [BUS_W-1:0]    data);
    logic [VEC_W-1:0] wide;
    wide = VEC_W'(data) << {word, 5'b00000};
    return wide[NUM_IRQ-1:0];
  endfunction

  logic                aligned_w;
  logic                hit_w;
  logic                wr_hit_w;
  win_e                win_w;
  logic [WIN_LOG2-3:0] word_w;
  logic [NUM_IRQ-1:0]  wmask_w;

  assign aligned_w = (addr_i[1:0] == 2'b00);
  assign win_w     = win_decode(addr_i[WIN_LOG2 +: 3]);
  assign word_w    = addr_i[WIN_LOG2-1:2];
  assign hit_w     = aligned_w && (win_w != WIN_NONE);
  assign wr_hit_w  = wr_i && hit_w;
  assign wmask_w   = spread(word_w, wdata_i);

  assign set_en_o = (wr_hit_w && win_w == WIN_SET_EN) ? wmask_w : '0;
  assign clr_en_o = (wr_hit_w && win_w == WIN_CLR_EN) ? wmask_w : '0;
  assign set_pd_o = (wr_hit_w && win_w == WIN_SET_PD) ? wmask_w : '0;
  assign clr_pd_o = (wr_hit_w && win_w == WIN_CLR_PD) ? wmask_w : '0;
  assign set_ac_o = (wr_hit_w && win_w == WIN_SET_AC) ? wmask_w : '0;
  assign clr_ac_o = (wr_hit_w && win_w == WIN_CLR_AC) ? wmask_w : '0;

  assign rd_win_o  = (rd_i && hit_w) ? win_w : WIN_NONE;
  assign rd_word_o = word_w;

  always_comb begin
    assert_one_window_R10: assert ($onehot0({|set_en_o, |clr_en_o, |set_pd_o,
                                             |clr_pd_o, |set_ac_o, |clr_ac_o}));
  end

endmodule

// File: rtl/irq_state_cell.sv
module irq_state_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_en_i,
  input  logic clr_en_i,
  input  logic set_pd_i,
  input  logic clr_pd_i,
  input  logic set_ac_i,
  input  logic clr_ac_i,
  input  logic line_i,
  input  logic level_i,
  output logic en_o,
  output logic pend_o,
  output logic act_o
);

  logic en_q;
  logic act_q;
  logic lat_q;   // edge: the pending bit; level: the software latch
  logic line_q;
  logic rise_w;

  assign rise_w = line_i && !line_q && !level_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      act_q  <= 1'b0;
      lat_q  <= 1'b0;
      line_q <= 1'b0;
    end else begin
      en_q   <= (en_q  || set_en_i) && !clr_en_i;
      act_q  <= (act_q || set_ac_i) && !clr_ac_i;
      lat_q  <= (lat_q && !clr_pd_i) || set_pd_i || rise_w;
      line_q <= line_i;
    end
  end

  assign en_o   = en_q;
  assign act_o  = act_q;
  assign pend_o = lat_q || (level_i && line_i);

  assert_set_en_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i |=> en_o);
  assert_hold_en_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_en_i && !clr_en_i) |=> $stable(en_o));
  assert_clr_en_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |=> !en_o);
  assert_set_pd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_pd_i |=> pend_o);
  assert_edge_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_w |=> pend_o);
  assert_edge_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_pd_i && !set_pd_i && !rise_w) |=> !lat_q);
  assert_level_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_pd_i && !set_pd_i && level_i) |=> (pend_o == (level_i && line_i)));
  assert_set_ac_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_ac_i |=> act_o);
  assert_clr_ac_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ac_i |=> !act_o);

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_bank_pkg::*;
#(
  parameter int NUM_IRQ  = 64,
  parameter int WIN_LOG2 = 7,
  parameter bit RD_REG   = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_i,
  input  win_e                win_i,
  input  logic [WIN_LOG2-3:0] word_i,
  input  logic [NUM_IRQ-1:0]  en_i,
  input  logic [NUM_IRQ-1:0]  pend_i,
  input  logic [NUM_IRQ-1:0]  act_i,
  output logic [BUS_W-1:0]    rdata_o,
  output logic                rvalid_o
);

  localparam int VEC_W = ((NUM_IRQ + BUS_W - 1) / BUS_W) * BUS_W;

  // Bits of interrupts word*32 .. word*32+31; numbers past NUM_IRQ give 0.
  function automatic logic [BUS_W-1:0] pick(input logic [NUM_IRQ-1:0]  vec,
                                            input logic [WIN_LOG2-3:0] word);
    logic [VEC_W-1:0] wide;
    wide = VEC_W'(vec) >> {word, 5'b00000};
    return wide[BUS_W-1:0];
  endfunction

  logic [BUS_W-1:0] src_w;

  always_comb begin
    case (win_i)
      WIN_SET_EN, WIN_CLR_EN: src_w = pick(en_i, word_i);
      WIN_SET_PD, WIN_CLR_PD: src_w = pick(pend_i, word_i);
      WIN_SET_AC, WIN_CLR_AC: src_w = pick(act_i, word_i);
      default:                src_w = '0;
    endcase
  end

  generate
    if (RD_REG) begin : g_reg
      logic [BUS_W-1:0] rdata_q;
      logic             rvalid_q;
      always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
          rdata_q  <= '0;
          rvalid_q <= 1'b0;
        end else begin
          rdata_q  <= src_w;
          rvalid_q <= rd_i;
        end
      end
      assign rdata_o  = rdata_q;
      assign rvalid_o = rvalid_q;

      assert_read_lag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_i |=> rvalid_o);
    end else begin : g_comb
      assign rdata_o  = src_w;
      assign rvalid_o = rd_i;
    end
  endgenerate

  assert_idle_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> (rdata_o == '0));

endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank
  import irq_bank_pkg::*;
#(
  parameter int NUM_IRQ  = 64,
  parameter int WIN_LOG2 = 7,
  parameter bit RD_REG   = 1'b0,
  localparam int ADDR_W  = WIN_LOG2 + 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [BUS_W-1:0]   wdata_i,
  output logic [BUS_W-1:0]   rdata_o,
  output logic               rd_valid_o,
  input  logic [NUM_IRQ-1:0] line_i,
  input  logic [NUM_IRQ-1:0] level_cfg_i,
  output logic [NUM_IRQ-1:0] enable_o,
  output logic [NUM_IRQ-1:0] pending_o,
  output logic [NUM_IRQ-1:0] active_o
);

  logic [NUM_IRQ-1:0]  set_en_w, clr_en_w, set_pd_w, clr_pd_w, set_ac_w, clr_ac_w;
  win_e                rd_win_w;
  logic [WIN_LOG2-3:0] rd_word_w;

  irq_reg_decode #(.NUM_IRQ(NUM_IRQ), .WIN_LOG2(WIN_LOG2)) u_decode (
    .wr_i      (wr_en_i),
    .rd_i      (rd_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .set_en_o  (set_en_w),
    .clr_en_o  (clr_en_w),
    .set_pd_o  (set_pd_w),
    .clr_pd_o  (clr_pd_w),
    .set_ac_o  (set_ac_w),
    .clr_ac_o  (clr_ac_w),
    .rd_win_o  (rd_win_w),
    .rd_word_o (rd_word_w)
  );

  generate
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_cell
      irq_state_cell u_cell (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .set_en_i (set_en_w[i]),
        .clr_en_i (clr_en_w[i]),
        .set_pd_i (set_pd_w[i]),
        .clr_pd_i (clr_pd_w[i]),
        .set_ac_i (set_ac_w[i]),
        .clr_ac_i (clr_ac_w[i]),
        .line_i   (line_i[i]),
        .level_i  (level_cfg_i[i]),
        .en_o     (enable_o[i]),
        .pend_o   (pending_o[i]),
        .act_o    (active_o[i])
      );
    end
  endgenerate

  irq_read_mux #(.NUM_IRQ(NUM_IRQ), .WIN_LOG2(WIN_LOG2), .RD_REG(RD_REG)) u_rmux (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_i     (rd_en_i),
    .win_i    (rd_win_w),
    .word_i   (rd_word_w),
    .en_i     (enable_o),
    .pend_i   (pending_o),
    .act_i    (active_o),
    .rdata_o  (rdata_o),
    .rvalid_o (rd_valid_o)
  );

endmodule

// File: tb/irq_state_bank_bench.sv
`timescale 1ns/1ps
module irq_state_bank_bench;

  localparam int N = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [9:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          rvalid;
  logic [N-1:0]  line = '0;
  logic [N-1:0]  lvl;
  logic [N-1:0]  en, pend, act;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  assign lvl = 64'h0000_FF00_0000_0000; // interrupts 40..47 are level

  always #10 clk = ~clk;

  irq_state_bank u_irq_state_bank (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr), .rd_en_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rd_valid_o(rvalid), .line_i(line),
    .level_cfg_i(lvl), .enable_o(en), .pending_o(pend), .active_o(act));

  task automatic check(input string req, input logic [63:0] actual, input logic [63:0] expected);
    n_checks++;
    if (actual !== expected) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, actual, expected);
    end
  endtask

  task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    #2 d = rdata;
    rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 enable", en, '0);
    check("R1 pending", pend, '0);
    check("R1 active", act, '0);
    bus_read(10'h000, d); check("R1 read", d, 0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    bus_write(10'h000, 32'h0000_00A5); check("R2 set", en, 64'h0A5);
    bus_write(10'h000, 32'h0000_0F00); check("R2 zero bits kept", en, 64'hFA5);
    bus_read(10'h000, d); check("R3 read set window", d, 32'hFA5);
    bus_read(10'h080, d); check("R3 read clear window", d, 32'hFA5);
    bus_write(10'h080, 32'h0000_0005); check("R3 clear", en, 64'hFA0);
    bus_read(10'h080, d); check("R3 read after clear", d, 32'hFA0);
  endtask

  task automatic t_mapping();
    logic [31:0] d;
    bus_write(10'h004, 32'h8000_0001);
    check("R4 upper word", en, 64'h8000_0001_0000_0FA0);
    bus_write(10'h008, 32'hFFFF_FFFF);
    check("R4 beyond NUM_IRQ", en, 64'h8000_0001_0000_0FA0);
    bus_read(10'h008, d); check("R4 beyond read", d, 0);
  endtask

  task automatic t_set_pending();
    logic [31:0] d;
    bus_write(10'h100, 32'h8); check("R5 set pending", pend, 64'h8);
    bus_read(10'h180, d); check("R5 read clear window", d, 32'h8);
  endtask

  task automatic t_edge();
    @(negedge clk); line[5] = 1'b1;
    @(negedge clk); check("R6 rise", pend, 64'h28);
    bus_write(10'h180, 32'h28); check("R6 clear while high", pend, 64'h0);
    @(negedge clk); line[5] = 1'b0;
    @(negedge clk); line[5] = 1'b1; wr = 1'b1; addr = 10'h180; wdata = 32'h20;
    @(negedge clk); wr = 1'b0;
    check("R6 edge beats clear", pend, 64'h20);
    bus_write(10'h180, 32'h20); line[5] = 1'b0;
  endtask

  task automatic t_level();
    logic [31:0] d;
    @(negedge clk); line[40] = 1'b1;
    #1 check("R7 line high", 64'(pend[40]), 1);
    bus_read(10'h104, d); check("R7 read level", d, 32'h100);
    @(negedge clk); line[40] = 1'b0;
    #1 check("R7 line low", 64'(pend[40]), 0);
    bus_write(10'h104, 32'h100); check("R7 latch set", 64'(pend[40]), 1);
    @(negedge clk); line[40] = 1'b1;
    bus_write(10'h184, 32'h100); check("R7 clear follows line", 64'(pend[40]), 1);
    @(negedge clk); line[40] = 1'b0;
    #1 check("R7 latch emptied", 64'(pend[40]), 0);
  endtask

  task automatic t_active();
    logic [31:0] d;
    bus_write(10'h200, 32'h3); check("R8 set", act, 64'h3);
    bus_write(10'h280, 32'h1); check("R8 clear", act, 64'h2);
    bus_read(10'h200, d); check("R8 read set window", d, 32'h2);
    bus_read(10'h280, d); check("R8 read clear window", d, 32'h2);
  endtask

  task automatic t_timing();
    @(negedge clk); wr = 1'b1; addr = 10'h000; wdata = 32'h0010_0000;
    #2 check("R9 no early update", 64'(en[20]), 0);
    @(negedge clk); wr = 1'b0;
    check("R9 update after edge", 64'(en[20]), 1);
    @(negedge clk); rd = 1'b1; addr = 10'h000;
    #2 check("R9 valid same cycle", 64'(rvalid), 1);
    check("R9 data same cycle", rdata, 32'h0010_0FA0);
    rd = 1'b0;
    #1 check("R9 valid drops", 64'(rvalid), 0);
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    logic [63:0] en0, pd0, ac0;
    en0 = en; pd0 = pend; ac0 = act;
    bus_write(10'h001, 32'hFFFF_FFFF); check("R10 misaligned write", en, en0);
    bus_write(10'h300, 32'hFFFF_FFFF);
    bus_write(10'h380, 32'hFFFF_FFFF);
    check("R10 unmapped enable", en, en0);
    check("R10 unmapped pending", pend, pd0);
    check("R10 unmapped active", act, ac0);
    bus_read(10'h002, d); check("R10 misaligned read", d, 0);
    bus_read(10'h300, d); check("R10 unmapped read", d, 0);
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_enable();
    t_mapping();
    t_set_pending();
    t_edge();
    t_level();
    t_active();
    t_timing();
    t_ignored();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule